// File: doc/BRIEF.md
# Four-Lane Stop-and-Wait Link Receiver

This block is the receiving end of a point-to-point board link. The link has four data wires and one handshake wire running back to the sender, and every wire is sampled on a clock that travels with the data. Each data wire carries its own serial stream. A lane becomes active when it sees a start marker. It then collects a fixed number of seven-bit Hamming codewords, corrects any single flipped bit, and writes the recovered nibbles into a shared packet buffer.

Once every active lane has delivered its codewords, the receiver answers on the handshake wire. The answer is a six-bit repetition pattern, so the sender can recover it by a majority vote over each half even if one bit is hit. An accepted packet is copied to the payload output and announced with a one-cycle strobe. A rejected packet is dropped. The sender may not start a new packet until the answer has gone out.

With the default parameters each lane carries 52 codewords, which gives an 832-bit payload. Lanes may start at different times, but only inside a bounded window. A running count of corrected codewords is kept for link-quality monitoring.

Top module: `quadLaneLinkRx`

## Requirements
- R1: While reset is asserted, and until the first packet arrives, hsOut, payloadValid and pktRejected are 0, and payload and corrCount are all zeros.
- R2: A lane arms on the cycle its input completes the bit sequence 1,1,1,0. The first codeword bit arrives on the next cycle. Each codeword is sent as Hamming positions 1 to 7 in that order. Positions 3, 5, 6 and 7 hold data bits 0 to 3. Positions 1, 2 and 4 hold even parity over positions {3,5,7}, {3,6,7} and {5,6,7} respectively.
- R3: The nibble from codeword k (counted from 0) of lane L lands in payload bits [(k*LANES+L)*4 +: 4].
- R4: A codeword with a nonzero syndrome has the bit at the syndrome's position inverted before the data is taken. A zero syndrome passes the codeword through unchanged.
- R5: corrCount grows by the number of codewords corrected in each cycle, summed over all lanes, and saturates at its all-ones value.
- R6: The reply starts two cycles after the cycle in which the last expected codeword bit arrived. An accepted packet is answered with 1,1,1,0,0,0 on hsOut, one bit per cycle. hsOut is 0 at all other times.
- R7: A lane that arms no more than SKEW_MAX cycles after the first lane is accepted. A lane that arms later than that, or never arms, makes the packet fail. The reply then goes out after every armed lane has finished, and a failed packet is answered with 0,0,0,1,1,1.
- R8: A failed packet leaves payload unchanged, produces no strobe, and sets pktRejected. pktRejected clears when the next packet is accepted.
- R9: payloadValid is high for exactly one cycle: the cycle right after the sixth bit of an accepting reply. payload takes the new packet in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded link clock; all lanes sample on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| laneIn | input | LANES | One serial data wire per lane |
| hsOut | output | 1 | Handshake wire back to the sender carrying the reply pattern |
| payload | output | LANES*CW_PER_LANE*4 | Most recently accepted packet |
| payloadValid | output | 1 | One-cycle strobe when a new packet is accepted |
| corrCount | output | CNT_W | Saturating count of corrected codewords |
| pktRejected | output | 1 | Set when the last answered packet was refused |

## Verification
The hardest case to reach from the ports is the edge of the skew window. A lane must arm exactly SKEW_MAX cycles after the first lane, or one cycle later, and in the later case it arms in the same cycle the window closes. The bench places each lane's marker at a chosen offset in a precomputed stream, so both sides of the edge are hit on exact cycles. A second hard case is correction in several lanes within a single cycle: aligned lanes carry flipped bits in the same codeword slot, which adds three at once and then drives the small counter into saturation.

// File: rtl/qlRxPkg.sv
package qlRxPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_REPLY
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armEn;
    logic clearLanes;
    logic capture;
  } rxCtrl_t;

  typedef struct packed {
    logic [3:0] nib;
    logic       fixed;
  } hamOut_t;

  // c[i] is Hamming position i+1; data on positions 3,5,6,7
  function automatic hamOut_t hamDecode(input logic [6:0] c);
    logic [2:0] syn;
    logic [6:0] f;
    hamOut_t    r;
    syn[0] = c[0] ^ c[2] ^ c[4] ^ c[6];
    syn[1] = c[1] ^ c[2] ^ c[5] ^ c[6];
    syn[2] = c[3] ^ c[4] ^ c[5] ^ c[6];
    f = c;
    if (syn != 3'd0) f[syn - 3'd1] = ~f[syn - 3'd1];
    r.nib   = {f[6], f[5], f[4], f[2]};
    r.fixed = (syn != 3'd0);
    return r;
  endfunction

endpackage

// File: rtl/qlLaneRx.sv
module qlLaneRx
  import qlRxPkg::*;
#(
  parameter int CW_PER_LANE = 52,
  parameter int SLOT_W      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              armEn,
  input  logic              clear,
  output logic              startSeen,
  output logic              armed,
  output logic              done,
  output logic              nibWe,
  output logic [3:0]        nib,
  output logic [SLOT_W-1:0] slot,
  output logic              corrected
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CW_PER_LANE - 1);

  logic [2:0] hist;
  logic [6:0] word;
  logic [2:0] bitCnt;
  hamOut_t    dec;

  assign startSeen = armEn && !armed && ({hist, bitIn} == 4'b1110);
  assign nibWe     = armed && !done && (bitCnt == 3'd6);
  assign dec       = hamDecode({bitIn, word[6:1]});
  assign nib       = dec.nib;
  assign corrected = nibWe && dec.fixed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hist <= '0;
    else       hist <= {hist[1:0], bitIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      done   <= 1'b0;
      bitCnt <= '0;
      slot   <= '0;
      word   <= '0;
    end else if (clear) begin
      armed  <= 1'b0;
      done   <= 1'b0;
      bitCnt <= '0;
      slot   <= '0;
    end else if (startSeen) begin
      armed <= 1'b1;
    end else if (armed && !done) begin
      word <= {bitIn, word[6:1]};
      if (bitCnt == 3'd6) begin
        bitCnt <= '0;
        if (slot == LAST_SLOT) done <= 1'b1;
        else                   slot <= slot + 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/qlRxDatapath.sv
module qlRxDatapath
  import qlRxPkg::*;
#(
  parameter int LANES       = 4,
  parameter int CW_PER_LANE = 52,
  parameter int CNT_W       = 16,
  parameter int SLOT_W      = 6,
  parameter int PAY_W       = 832
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] laneIn,
  input  rxCtrl_t          ctrl,
  output logic             startAny,
  output logic [LANES-1:0] armedV,
  output logic [LANES-1:0] doneV,
  output logic [PAY_W-1:0] payload,
  output logic [CNT_W-1:0] corrCount
);

  localparam int SUM_W = $clog2(LANES + 1);
  localparam int EXT_W = CNT_W + 1;

  logic [LANES-1:0]  startV;
  logic [LANES-1:0]  weV;
  logic [LANES-1:0]  corrV;
  logic [3:0]        nibV  [LANES];
  logic [SLOT_W-1:0] slotV [LANES];
  logic [PAY_W-1:0]  workBuf;
  logic [SUM_W-1:0]  corrSum;
  logic [EXT_W-1:0]  nextCnt;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    qlLaneRx #(.CW_PER_LANE(CW_PER_LANE), .SLOT_W(SLOT_W)) uLane (
      .clk      (clk),
      .rstN     (rstN),
      .bitIn    (laneIn[l]),
      .armEn    (ctrl.armEn),
      .clear    (ctrl.clearLanes),
      .startSeen(startV[l]),
      .armed    (armedV[l]),
      .done     (doneV[l]),
      .nibWe    (weV[l]),
      .nib      (nibV[l]),
      .slot     (slotV[l]),
      .corrected(corrV[l])
    );
  end

  assign startAny = |startV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workBuf <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        for (int k = 0; k < CW_PER_LANE; k++) begin
          if (weV[l] && (slotV[l] == SLOT_W'(k)))
            workBuf[(k*LANES + l)*4 +: 4] <= nibV[l];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             payload <= '0;
    else if (ctrl.capture) payload <= workBuf;
  end

  always_comb begin
    corrSum = '0;
    for (int l = 0; l < LANES; l++) corrSum = corrSum + SUM_W'(corrV[l]);
  end

  assign nextCnt = {1'b0, corrCount} + EXT_W'(corrSum);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               corrCount <= '0;
    else if (nextCnt[CNT_W]) corrCount <= '1;
    else                     corrCount <= nextCnt[CNT_W-1:0];
  end

endmodule

// File: rtl/qlRxCtrl.sv
module qlRxCtrl
  import qlRxPkg::*;
#(
  parameter int LANES    = 4,
  parameter int SKEW_MAX = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startAny,
  input  logic [LANES-1:0] armedV,
  input  logic [LANES-1:0] doneV,
  output rxCtrl_t          ctrl,
  output logic             hsOut,
  output logic             payloadValid,
  output logic             pktRejected
);

  localparam int SKEW_W = $clog2(SKEW_MAX + 1);
  localparam logic [SKEW_W-1:0] SKEW_LIM = SKEW_W'(SKEW_MAX);

  rxState_t    state;
  logic        bad;
  logic        okReg;
  logic [SKEW_W-1:0] skewCnt;
  logic [2:0]  replyCnt;
  logic        allArmed;
  logic        pending;
  logic        finished;
  logic        timeout;
  logic        replyEnd;

  assign allArmed = &armedV;
  assign pending  = |(armedV & ~doneV);
  assign finished = !pending && (bad || allArmed);
  assign timeout  = (state == ST_RECV) && !bad && !allArmed && (skewCnt == SKEW_LIM);
  assign replyEnd = (state == ST_REPLY) && (replyCnt == 3'd5);

  assign ctrl.armEn      = (state == ST_IDLE) || ((state == ST_RECV) && !bad);
  assign ctrl.clearLanes = replyEnd;
  assign ctrl.capture    = replyEnd && okReg;

  // first half high for accept, second half high for refuse
  assign hsOut = (state == ST_REPLY) && (okReg ^ (replyCnt >= 3'd3));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      bad          <= 1'b0;
      okReg        <= 1'b0;
      skewCnt      <= '0;
      replyCnt     <= '0;
      payloadValid <= 1'b0;
      pktRejected  <= 1'b0;
    end else begin
      payloadValid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startAny) begin
            state   <= ST_RECV;
            skewCnt <= '0;
            bad     <= 1'b0;
          end
        end
        ST_RECV: begin
          if (!allArmed && (skewCnt != SKEW_LIM)) skewCnt <= skewCnt + 1'b1;
          if (timeout) bad <= 1'b1;
          if (finished) begin
            state       <= ST_REPLY;
            replyCnt    <= '0;
            okReg       <= !bad;
            pktRejected <= bad;
          end
        end
        ST_REPLY: begin
          if (replyEnd) begin
            state        <= ST_IDLE;
            payloadValid <= okReg;
          end else begin
            replyCnt <= replyCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/quadLaneLinkRx.sv
module quadLaneLinkRx
  import qlRxPkg::*;
#(
  parameter int  LANES       = 4,
  parameter int  CW_PER_LANE = 52,
  parameter int  SKEW_MAX    = 16,
  parameter int  CNT_W       = 16,
  localparam int PAY_W       = LANES * CW_PER_LANE * 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] laneIn,
  output logic             hsOut,
  output logic [PAY_W-1:0] payload,
  output logic             payloadValid,
  output logic [CNT_W-1:0] corrCount,
  output logic             pktRejected
);

  localparam int SLOT_W = $clog2(CW_PER_LANE + 1);

  rxCtrl_t          ctrl;
  logic             startAny;
  logic [LANES-1:0] armedV;
  logic [LANES-1:0] doneV;

  qlRxDatapath #(
    .LANES(LANES), .CW_PER_LANE(CW_PER_LANE), .CNT_W(CNT_W),
    .SLOT_W(SLOT_W), .PAY_W(PAY_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .laneIn   (laneIn),
    .ctrl     (ctrl),
    .startAny (startAny),
    .armedV   (armedV),
    .doneV    (doneV),
    .payload  (payload),
    .corrCount(corrCount)
  );

  qlRxCtrl #(.LANES(LANES), .SKEW_MAX(SKEW_MAX)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startAny    (startAny),
    .armedV      (armedV),
    .doneV       (doneV),
    .ctrl        (ctrl),
    .hsOut       (hsOut),
    .payloadValid(payloadValid),
    .pktRejected (pktRejected)
  );

endmodule

// File: rtl/qlRxChk.sv
module qlRxChk #(
  parameter int PAY_W = 832,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             hsOut,
  input logic [PAY_W-1:0] payload,
  input logic             payloadValid,
  input logic [CNT_W-1:0] corrCount,
  input logic             pktRejected
);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    payloadValid |=> !payloadValid);

  a_r9_payload_moves_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(payload) |-> payloadValid);

  a_r8_no_strobe_on_reject: assert property (@(posedge clk) disable iff (!rstN)
    payloadValid |-> !pktRejected);

  a_r5_count_never_drops: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(corrCount) |-> (corrCount > $past(corrCount)));

  a_r6_reply_three_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsOut) |=> hsOut ##1 hsOut ##1 !hsOut);

endmodule

bind quadLaneLinkRx qlRxChk #(.PAY_W(PAY_W), .CNT_W(CNT_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .hsOut       (hsOut),
  .payload     (payload),
  .payloadValid(payloadValid),
  .corrCount   (corrCount),
  .pktRejected (pktRejected)
);

// File: tb/tb_quadLaneLinkRx.sv
module tb_quadLaneLinkRx;

  localparam int LANES  = 4;
  localparam int CW     = 3;
  localparam int SKEW   = 16;
  localparam int CNT_W  = 5;
  localparam int PAY_W  = LANES * CW * 4;
  localparam int MAXLEN = 64;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [LANES-1:0] laneIn = '0;
  logic             hsOut;
  logic [PAY_W-1:0] payload;
  logic             payloadValid;
  logic [CNT_W-1:0] corrCount;
  logic             pktRejected;

  quadLaneLinkRx #(.LANES(LANES), .CW_PER_LANE(CW), .SKEW_MAX(SKEW), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .laneIn(laneIn), .hsOut(hsOut), .payload(payload),
    .payloadValid(payloadValid), .corrCount(corrCount), .pktRejected(pktRejected)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  int         laneOff [LANES];
  bit         laneOn  [LANES];
  logic [3:0] dat     [LANES][CW];
  logic [6:0] flip    [LANES][CW];
  logic [PAY_W-1:0] expPay = '0;
  int         expCorr = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bit i holds Hamming position i+1
  function automatic logic [6:0] enc(input logic [3:0] d);
    logic p1, p2, p4;
    p1 = d[0] ^ d[1] ^ d[3];
    p2 = d[0] ^ d[2] ^ d[3];
    p4 = d[1] ^ d[2] ^ d[3];
    return {d[3], d[2], d[1], p4, d[0], p2, p1};
  endfunction

  task automatic setup(input int mult, input int add);
    for (int l = 0; l < LANES; l++) begin
      laneOff[l] = 0;
      laneOn[l]  = 1'b1;
      for (int k = 0; k < CW; k++) begin
        dat[l][k]  = 4'((((k*LANES + l) * mult) + add) & 15);
        flip[l][k] = 7'd0;
      end
    end
  endtask

  task automatic runPkt(input string ctx, input bit expAck);
    logic strm [LANES][MAXLEN];
    logic hsT [128];
    logic vT  [128];
    logic [6:0] cw;
    int jl, len, base, nValid, o;
    jl = 0;
    for (int l = 0; l < LANES; l++)
      for (int j = 0; j < MAXLEN; j++) strm[l][j] = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (laneOn[l]) begin
        o = laneOff[l];
        strm[l][o] = 1'b1; strm[l][o+1] = 1'b1; strm[l][o+2] = 1'b1; strm[l][o+3] = 1'b0;
        for (int k = 0; k < CW; k++) begin
          cw = enc(dat[l][k]) ^ flip[l][k];
          for (int b = 0; b < 7; b++) strm[l][o + 4 + k*7 + b] = cw[b];
        end
        if (o + 3 + CW*7 > jl) jl = o + 3 + CW*7;
      end
    end
    len = jl + 1;
    @(negedge clk);
    base = cyc;
    for (int j = 0; j < jl + 12; j++) begin
      hsT[cyc - base] = hsOut;
      vT[cyc - base]  = payloadValid;
      for (int l = 0; l < LANES; l++) laneIn[l] = (j < len) ? strm[l][j] : 1'b0;
      @(negedge clk);
    end
    // R6: idle before, six reply bits, idle after
    check({ctx, " R6 idle before reply"}, 64'(hsT[jl+1]), 64'd0);
    for (int i = 0; i < 6; i++)
      check({ctx, (expAck ? " R6 accept bit" : " R7 refuse bit")}, 64'(hsT[jl+2+i]),
            64'(expAck ? (i < 3) : (i >= 3)));
    check({ctx, " R6 idle after reply"}, 64'(hsT[jl+8]), 64'd0);
    nValid = 0;
    for (int j = 0; j < jl + 12; j++) if (vT[j] === 1'b1) nValid++;
    check({ctx, " R9 strobe cycle"}, 64'(vT[jl+8]), 64'(expAck));
    check({ctx, " R9 strobe count"}, 64'(nValid), 64'(expAck ? 1 : 0));
    if (expAck)
      for (int l = 0; l < LANES; l++)
        for (int k = 0; k < CW; k++) expPay[(k*LANES + l)*4 +: 4] = dat[l][k];
    for (int l = 0; l < LANES; l++)
      if (laneOn[l])
        for (int k = 0; k < CW; k++)
          if (flip[l][k] != 7'd0 && expCorr < CNT_MAX) expCorr++;
    check({ctx, (expAck ? " R3 payload" : " R8 payload kept")}, 64'(payload), 64'(expPay));
    check({ctx, " R5 corrected count"}, 64'(corrCount), 64'(expCorr));
    check({ctx, " R8 reject flag"}, 64'(pktRejected), 64'(!expAck));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hsOut", 64'(hsOut), 64'd0);
    check("R1 payloadValid", 64'(payloadValid), 64'd0);
    check("R1 pktRejected", 64'(pktRejected), 64'd0);
    check("R1 payload", 64'(payload), 64'd0);
    check("R1 corrCount", 64'(corrCount), 64'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after release", 64'(hsOut), 64'd0);

    // R2 R3: clean packets over several data patterns
    for (int p = 0; p < 5; p++) begin
      setup(p * 3 + 1, p * 5);
      if (p == 3) for (int l = 0; l < LANES; l++) for (int k = 0; k < CW; k++) dat[l][k] = 4'hF;
      if (p == 4) for (int l = 0; l < LANES; l++) for (int k = 0; k < CW; k++) dat[l][k] = 4'h0;
      runPkt("R2 clean", 1'b1);
    end

    // R4: every single-bit position on every lane
    for (int l = 0; l < LANES; l++)
      for (int b = 0; b < 7; b++) begin
        setup(5, b + l);
        flip[l][b % CW] = 7'(1 << b);
        runPkt("R4 single flip", 1'b1);
      end

    // R5: three lanes corrected in one cycle, then saturation
    setup(7, 2);
    for (int l = 0; l < 3; l++) flip[l][1] = 7'(1 << (l + 2));
    runPkt("R5 simultaneous", 1'b1);
    setup(9, 1);
    flip[3][0] = 7'b0100000;
    runPkt("R5 saturate", 1'b1);

    // R7: skew inside the window
    setup(11, 3);
    laneOff[0] = 0; laneOff[1] = 5; laneOff[2] = 11; laneOff[3] = 16;
    runPkt("R7 skew 16 last lane", 1'b1);
    setup(13, 4);
    laneOff[0] = 16; laneOff[1] = 0; laneOff[2] = 8; laneOff[3] = 3;
    runPkt("R7 skew 16 first lane", 1'b1);

    // R7 R8: one cycle too late
    setup(3, 9);
    laneOff[3] = 17;
    runPkt("R7 skew 17", 1'b0);
    // R7 R8: lane never starts
    setup(6, 7);
    laneOn[2] = 1'b0;
    runPkt("R7 silent lane", 1'b0);
    // R8: accepted packet clears the flag
    setup(2, 11);
    runPkt("R8 recovery", 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule